// File: doc/BRIEF.md
# Highway-Aware Route Decision Unit

This block is the route computation stage of a router in the lower mesh of a two-level clustered mesh network. The network groups routers into square clusters, and each cluster has one attachment router that leads up to a coarser mesh of express highway links. When a head flit arrives, the unit counts the hops the flit needs on the plain lower mesh with X-then-Y routing. It also counts the hops it needs when it travels to its own cluster's attachment router, crosses the upper mesh cluster by cluster, and descends at the target cluster's attachment router. The highway is taken only when that count is strictly smaller and the flit started inside the cluster it is now in. The result is a one-hot output port request.

A packet is a head flit followed by zero or more body flits. A burst flag on each flit marks that another flit of the same packet follows. A two-state machine (`ST_HEAD`, `ST_BODY`) keeps the head's decision for every flit of the packet. The transition `ST_HEAD`→`ST_BODY` happens on a valid flit with the burst flag set. The transition `ST_BODY`→`ST_HEAD` happens on a valid flit with the burst flag clear. Reset forces `ST_HEAD`.

A parameter selects one of three variants:
- **central**: the attachment sits at the cluster centre, and every router may decide.
- **corner**: the attachment sits at the cluster's low corner, and flits arriving on the south or west inputs never go up.
- **bypass**: only the injecting router decides, and it sends highway flits straight onto a dedicated bypass link, which uses the up request bit.

Top module: `hwy_route_unit`

## Requirements
- R1: Each valid input flit gives exactly one valid output one clock later. In that output, exactly one bit of `out_req` is set. The bit positions are: bit0 local, bit1 north, bit2 east, bit3 south, bit4 west, bit5 up/highway. When `out_valid` is low, `out_req` is zero.
- R2: Plain routing is X first, then Y. East means the target x is greater than the router's x, and west means it is smaller. Once the x values match, north means the target y is greater and south means it is smaller. When x and y both match, the request is local.
- R3: The cluster index is the coordinate divided by the parameter `EDGE`. The attachment coordinate is:
  - central and bypass variants: index·EDGE + EDGE/2;
  - corner variant: index·EDGE.

  The highway hop count is the sum of three terms: the Manhattan distance from the router to its own cluster's attachment, the Manhattan distance between the two cluster indices, and the Manhattan distance from the target cluster's attachment to the target. When the highway is chosen, the request is as follows:
  - at the attachment router, and always in the bypass variant: up;
  - elsewhere: the X-then-Y direction toward the attachment.
- R4: When the two hop counts are equal, the flit stays on the lower mesh.
- R5: The highway is never chosen when the source cluster index differs from the router's own cluster index in x or in y.
- R6: A flit that arrives on the up port (`in_port` = 5) is routed by plain X-then-Y and never gets the up request. The input port codes are: 0 local, 1 north, 2 east, 3 south, 4 west, 5 up.
- R7: Body flits reuse the head flit's request, whatever header they carry, until a flit with the burst flag clear ends the packet.
- R8: In the bypass variant, only flits on the local input (`in_port` = 0) may get the up request.
- R9: In the corner variant, flits on the south (3) or west (4) input never get the up request.
- R10: While reset is low, and in the first cycle after it, `out_valid` is low. Reset abandons a packet in progress, so the next flit is treated as a head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A flit is present this cycle |
| in_burst | input | 1 | Another flit of this packet follows |
| in_port | input | 3 | Input port of the flit (0 local,1 N,2 E,3 S,4 W,5 up) |
| cur_x | input | XW | This router's x coordinate |
| cur_y | input | YW | This router's y coordinate |
| src_x | input | XW | Source x from the header |
| src_y | input | YW | Source y from the header |
| dst_x | input | XW | Target x from the header |
| dst_y | input | YW | Target y from the header |
| out_valid | output | 1 | Registered request is valid |
| out_req | output | 6 | One-hot output port request |

## Verification
On every cycle, the assertions check the following:
- the request is one-hot and appears only one cycle after a flit;
- an up request is only ever granted to a flit whose source lies in the router's own cluster;
- a flit arriving from the upper level is never sent back up;
- in the bypass and corner variants, up is never requested for inputs that must not turn up.

Only the bench's scenarios can show the remaining behaviour, using a behavioural reference model that runs all three variants side by side:
- that the hop comparison selects the right level, and that ties stay on the lower mesh;
- that a highway flit is steered toward the attachment router;
- that body flits keep the head's request even when their headers change;
- that a reset in the middle of a packet discards the held request.

// File: rtl/hwy_pkg.sv
package hwy_pkg;

    localparam int MODE_CENTRAL = 0;
    localparam int MODE_CORNER  = 1;
    localparam int MODE_BYPASS  = 2;

    localparam int REQ_W    = 6;
    localparam int RQ_LOCAL = 0;
    localparam int RQ_NORTH = 1;
    localparam int RQ_EAST  = 2;
    localparam int RQ_SOUTH = 3;
    localparam int RQ_WEST  = 4;
    localparam int RQ_UP    = 5;

    typedef enum logic [2:0] {
        PIN_LOCAL = 3'd0,
        PIN_NORTH = 3'd1,
        PIN_EAST  = 3'd2,
        PIN_SOUTH = 3'd3,
        PIN_WEST  = 3'd4,
        PIN_UP    = 3'd5
    } in_port_e;

    typedef enum logic [0:0] {
        ST_HEAD = 1'b0,
        ST_BODY = 1'b1
    } route_state_e;

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/hwy_cluster_geo.sv
module hwy_cluster_geo #(
    parameter int AW     = 4,
    parameter int EDGE   = 2,
    parameter int LIMIT  = 12,
    parameter bit CORNER = 1'b0
) (
    input  logic [AW-1:0] coord,
    output logic [AW-1:0] idx,
    output logic [AW-1:0] attach
);
    int c_i;
    int i_i;
    int b_i;
    int a_i;

    always_comb begin
        c_i = int'(coord);
        i_i = c_i / EDGE;
        b_i = i_i * EDGE;
        if (CORNER) begin
            a_i = b_i;
        end else begin
            a_i = b_i + EDGE / 2;
        end
        if (a_i > LIMIT - 1) begin
            a_i = LIMIT - 1;
        end
        idx    = AW'(i_i);
        attach = AW'(a_i);
    end
endmodule

// File: rtl/hwy_hop_count.sv
module hwy_hop_count
    import hwy_pkg::*;
#(
    parameter int XW = 4,
    parameter int YW = 4,
    parameter int DW = 7
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [XW-1:0] cur_ax,
    input  logic [YW-1:0] cur_ay,
    input  logic [XW-1:0] dst_ax,
    input  logic [YW-1:0] dst_ay,
    input  logic [XW-1:0] cur_cx,
    input  logic [YW-1:0] cur_cy,
    input  logic [XW-1:0] dst_cx,
    input  logic [YW-1:0] dst_cy,
    output logic [DW-1:0] mesh_hops,
    output logic [DW-1:0] hwy_hops
);
    int climb_i;
    int cross_i;
    int land_i;
    int flat_i;

    always_comb begin
        flat_i  = absdiff(int'(cur_x), int'(dst_x)) + absdiff(int'(cur_y), int'(dst_y));
        climb_i = absdiff(int'(cur_x), int'(cur_ax)) + absdiff(int'(cur_y), int'(cur_ay));
        cross_i = absdiff(int'(cur_cx), int'(dst_cx)) + absdiff(int'(cur_cy), int'(dst_cy));
        land_i  = absdiff(int'(dst_ax), int'(dst_x)) + absdiff(int'(dst_ay), int'(dst_y));
        mesh_hops = DW'(flat_i);
        hwy_hops  = DW'(climb_i + cross_i + land_i);
    end
endmodule

// File: rtl/hwy_port_select.sv
module hwy_port_select
    import hwy_pkg::*;
#(
    parameter int XW   = 4,
    parameter int YW   = 4,
    parameter int DW   = 7,
    parameter int EDGE = 2,
    parameter int MODE = MODE_CENTRAL
) (
    input  logic [2:0]       in_port,
    input  logic [XW-1:0]    cur_x,
    input  logic [YW-1:0]    cur_y,
    input  logic [XW-1:0]    src_x,
    input  logic [YW-1:0]    src_y,
    input  logic [XW-1:0]    dst_x,
    input  logic [YW-1:0]    dst_y,
    input  logic [XW-1:0]    cur_ax,
    input  logic [YW-1:0]    cur_ay,
    input  logic [XW-1:0]    cur_cx,
    input  logic [YW-1:0]    cur_cy,
    input  logic [DW-1:0]    mesh_hops,
    input  logic [DW-1:0]    hwy_hops,
    output logic [REQ_W-1:0] req
);
    in_port_e    ip;
    logic        own_cluster;
    logic        variant_ok;
    logic        eligible;
    logic        at_attach;
    logic [XW-1:0] aim_x;
    logic [YW-1:0] aim_y;

    assign ip = in_port_e'(in_port);

    always_comb begin
        own_cluster = (XW'(int'(src_x) / EDGE) == cur_cx) &&
                      (YW'(int'(src_y) / EDGE) == cur_cy);
    end

    generate
        if (MODE == MODE_BYPASS) begin : g_bypass
            assign variant_ok = (ip == PIN_LOCAL);
        end else if (MODE == MODE_CORNER) begin : g_corner
            assign variant_ok = (ip != PIN_SOUTH) && (ip != PIN_WEST);
        end else begin : g_central
            assign variant_ok = 1'b1;
        end
    endgenerate

    assign eligible  = own_cluster && variant_ok && (ip != PIN_UP) &&
                       (hwy_hops < mesh_hops);
    assign at_attach = (cur_x == cur_ax) && (cur_y == cur_ay);

    always_comb begin
        aim_x = eligible ? cur_ax : dst_x;
        aim_y = eligible ? cur_ay : dst_y;
        req   = '0;
        if (eligible && (at_attach || (MODE == MODE_BYPASS))) begin
            req[RQ_UP] = 1'b1;
        end else if (aim_x > cur_x) begin
            req[RQ_EAST] = 1'b1;
        end else if (aim_x < cur_x) begin
            req[RQ_WEST] = 1'b1;
        end else if (aim_y > cur_y) begin
            req[RQ_NORTH] = 1'b1;
        end else if (aim_y < cur_y) begin
            req[RQ_SOUTH] = 1'b1;
        end else begin
            req[RQ_LOCAL] = 1'b1;
        end
    end
endmodule

// File: rtl/hwy_route_unit.sv
module hwy_route_unit
    import hwy_pkg::*;
#(
    parameter int MESH_X = 12,
    parameter int MESH_Y = 12,
    parameter int EDGE   = 2,
    parameter int MODE   = MODE_CENTRAL,
    localparam int XW    = $clog2(MESH_X),
    localparam int YW    = $clog2(MESH_Y),
    localparam int DW    = $clog2(MESH_X + MESH_Y) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_burst,
    input  logic [2:0]    in_port,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] src_x,
    input  logic [YW-1:0] src_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output logic          out_valid,
    output logic [5:0]    out_req
);
    localparam bit AT_CORNER = (MODE == MODE_CORNER);

    logic [XW-1:0] pt_x [2];
    logic [YW-1:0] pt_y [2];
    logic [XW-1:0] cl_x [2];
    logic [YW-1:0] cl_y [2];
    logic [XW-1:0] at_x [2];
    logic [YW-1:0] at_y [2];

    assign pt_x[0] = cur_x;
    assign pt_y[0] = cur_y;
    assign pt_x[1] = dst_x;
    assign pt_y[1] = dst_y;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_geo
            hwy_cluster_geo #(.AW(XW), .EDGE(EDGE), .LIMIT(MESH_X), .CORNER(AT_CORNER)) u_gx (
                .coord(pt_x[g]), .idx(cl_x[g]), .attach(at_x[g]));
            hwy_cluster_geo #(.AW(YW), .EDGE(EDGE), .LIMIT(MESH_Y), .CORNER(AT_CORNER)) u_gy (
                .coord(pt_y[g]), .idx(cl_y[g]), .attach(at_y[g]));
        end
    endgenerate

    logic [DW-1:0] mesh_hops;
    logic [DW-1:0] hwy_hops;

    hwy_hop_count #(.XW(XW), .YW(YW), .DW(DW)) u_hops (
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .cur_ax(at_x[0]), .cur_ay(at_y[0]), .dst_ax(at_x[1]), .dst_ay(at_y[1]),
        .cur_cx(cl_x[0]), .cur_cy(cl_y[0]), .dst_cx(cl_x[1]), .dst_cy(cl_y[1]),
        .mesh_hops(mesh_hops), .hwy_hops(hwy_hops));

    logic [REQ_W-1:0] fresh_req;

    hwy_port_select #(.XW(XW), .YW(YW), .DW(DW), .EDGE(EDGE), .MODE(MODE)) u_sel (
        .in_port(in_port), .cur_x(cur_x), .cur_y(cur_y),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .cur_ax(at_x[0]), .cur_ay(at_y[0]), .cur_cx(cl_x[0]), .cur_cy(cl_y[0]),
        .mesh_hops(mesh_hops), .hwy_hops(hwy_hops), .req(fresh_req));

    route_state_e     state_q, state_d;
    logic [REQ_W-1:0] held_q, held_d;
    logic [REQ_W-1:0] req_now;

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_HEAD: begin
                if (in_valid) begin
                    held_d = fresh_req;
                    if (in_burst) begin
                        state_d = ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                if (in_valid && !in_burst) begin
                    state_d = ST_HEAD;
                end
            end
        endcase
    end

    assign req_now = (state_q == ST_HEAD) ? fresh_req : held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_req   <= '0;
        end else begin
            out_valid <= in_valid;
            out_req   <= in_valid ? req_now : '0;
        end
    end
endmodule

// File: rtl/hwy_route_chk.sv
module hwy_route_chk
    import hwy_pkg::*;
#(
    parameter int XW   = 4,
    parameter int YW   = 4,
    parameter int EDGE = 2,
    parameter int MODE = MODE_CENTRAL
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    in_port,
    input logic [XW-1:0] cur_x,
    input logic [YW-1:0] cur_y,
    input logic [XW-1:0] src_x,
    input logic [YW-1:0] src_y,
    input logic          out_valid,
    input logic [5:0]    out_req
);
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_req) == 1)); // R1

    AST_FLIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R1

    AST_QUIET_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_req == 6'd0)); // R1

    AST_OWN_CLUSTER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_req[RQ_UP]) |->
        ((int'($past(src_x)) / EDGE == int'($past(cur_x)) / EDGE) &&
         (int'($past(src_y)) / EDGE == int'($past(cur_y)) / EDGE))); // R5

    AST_NO_REASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(in_port) == 3'd5)) |-> !out_req[RQ_UP]); // R6

    generate
        if (MODE == MODE_CORNER) begin : g_corner_chk
            AST_CORNER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && (($past(in_port) == 3'd3) || ($past(in_port) == 3'd4)))
                |-> !out_req[RQ_UP]); // R9
        end
        if (MODE == MODE_BYPASS) begin : g_bypass_chk
            AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && ($past(in_port) != 3'd0)) |-> !out_req[RQ_UP]); // R8
        end
    endgenerate
endmodule

bind hwy_route_unit hwy_route_chk #(.XW(XW), .YW(YW), .EDGE(EDGE), .MODE(MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
    .cur_x(cur_x), .cur_y(cur_y), .src_x(src_x), .src_y(src_y),
    .out_valid(out_valid), .out_req(out_req));

// File: tb/sim_hwy_route_unit.sv
module sim_hwy_route_unit;
    localparam int MX = 12;
    localparam int MY = 12;
    localparam int E  = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_burst = 1'b0;
    logic [2:0] in_port = 3'd0;
    logic [3:0] cur_x = '0, cur_y = '0, src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
    logic       ov [3];
    logic [5:0] orq [3];

    hwy_route_unit #(.MESH_X(MX), .MESH_Y(MY), .EDGE(E), .MODE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_burst(in_burst), .in_port(in_port),
        .cur_x(cur_x), .cur_y(cur_y), .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .out_valid(ov[0]), .out_req(orq[0]));
    hwy_route_unit #(.MESH_X(MX), .MESH_Y(MY), .EDGE(E), .MODE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_burst(in_burst), .in_port(in_port),
        .cur_x(cur_x), .cur_y(cur_y), .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .out_valid(ov[1]), .out_req(orq[1]));
    hwy_route_unit #(.MESH_X(MX), .MESH_Y(MY), .EDGE(E), .MODE(2)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_burst(in_burst), .in_port(in_port),
        .cur_x(cur_x), .cur_y(cur_y), .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .out_valid(ov[2]), .out_req(orq[2]));

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R10";
    bit         exp_v [3];
    logic [5:0] exp_r [3];
    bit         body  [3];
    logic [5:0] held  [3];

    function automatic int ad(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic int anchor(input int mode, input int c, input int lim);
        int base;
        base = (c / E) * E;
        if (mode == 1) return base;
        return (base + E / 2 > lim - 1) ? lim - 1 : base + E / 2;
    endfunction

    function automatic int xy_dir(input int cx, input int cy, input int tx, input int ty);
        if (tx > cx) return 2;
        if (tx < cx) return 4;
        if (ty > cy) return 1;
        if (ty < cy) return 3;
        return 0;
    endfunction

    // reference decision for R2..R9, built from the requirement text
    function automatic int ref_port(input int mode, input int cx, input int cy, input int sx,
                                    input int sy, input int dx, input int dy, input int ip);
        int ax, ay, bx, by, flat, hw;
        bit own, ok;
        ax = anchor(mode, cx, MX); ay = anchor(mode, cy, MY);
        bx = anchor(mode, dx, MX); by = anchor(mode, dy, MY);
        flat = ad(cx, dx) + ad(cy, dy);
        hw = ad(cx, ax) + ad(cy, ay) + ad(cx / E, dx / E) + ad(cy / E, dy / E) + ad(bx, dx) + ad(by, dy);
        own = (sx / E == cx / E) && (sy / E == cy / E);
        ok = own && ip != 5 && (mode == 0 || (mode == 1 && ip != 3 && ip != 4) || (mode == 2 && ip == 0));
        if (ok && hw < flat) begin
            if (mode == 2 || (cx == ax && cy == ay)) return 5;
            return xy_dir(cx, cy, ax, ay);
        end
        return xy_dir(cx, cy, dx, dy);
    endfunction

    task automatic compare_all();
        for (int k = 0; k < 3; k++) begin
            n_vec++;
            if (ov[k] !== exp_v[k] || orq[k] !== exp_r[k]) begin
                n_bad++;
                $display("FAIL %s u%0d: valid=%0b req=%b expected valid=%0b req=%b",
                         tag, k, ov[k], orq[k], exp_v[k], exp_r[k]);
            end
        end
    endtask

    task automatic predict();
        logic [5:0] r;
        for (int k = 0; k < 3; k++) begin
            exp_v[k] = in_valid && rst_n;
            exp_r[k] = '0;
            if (!rst_n) begin
                body[k] = 1'b0;
            end else if (in_valid) begin
                if (body[k]) r = held[k];
                else r = 6'(1) << ref_port(k, int'(cur_x), int'(cur_y), int'(src_x), int'(src_y),
                                           int'(dst_x), int'(dst_y), int'(in_port));
                if (!body[k]) held[k] = r;
                body[k] = in_burst;
                exp_r[k] = r;
            end
        end
    endtask

    task automatic step(input string t, input bit v, input bit b, input int ip, input int cx,
                        input int cy, input int sx, input int sy, input int dx, input int dy);
        @(negedge clk);
        compare_all();
        tag = t;
        in_valid = v; in_burst = b; in_port = 3'(ip);
        cur_x = 4'(cx); cur_y = 4'(cy); src_x = 4'(sx); src_y = 4'(sy);
        dst_x = 4'(dx); dst_y = 4'(dy);
        predict();
    endtask

    task automatic set_reset(input bit r);
        @(negedge clk);
        compare_all();
        tag = "R10";
        rst_n = r; in_valid = 1'b0; in_burst = 1'b0;
        predict();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            exp_v[k] = 1'b0; exp_r[k] = '0; body[k] = 1'b0; held[k] = '0;
        end
        // R10: outputs quiet while in reset
        step("R10", 1, 0, 0, 4, 4, 4, 4, 9, 9);
        step("R10", 1, 0, 0, 4, 4, 4, 4, 9, 9);
        set_reset(1'b1);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: X first then Y, local when equal
        step("R2", 1, 0, 0, 4, 4, 4, 4, 4, 4);
        step("R2", 1, 0, 2, 4, 4, 9, 9, 6, 1);
        step("R2", 1, 0, 1, 4, 4, 9, 9, 0, 8);
        step("R2", 1, 0, 3, 4, 4, 9, 9, 4, 9);
        step("R2", 1, 0, 4, 4, 4, 9, 9, 4, 0);
        // R3: highway at attachment, and steering toward attachment
        step("R3", 1, 0, 0, 1, 1, 0, 0, 11, 11);
        step("R3", 1, 0, 0, 0, 1, 0, 1, 0, 11);
        step("R3", 1, 0, 1, 0, 1, 0, 1, 0, 11);
        // R4: equal hop counts stay on mesh
        step("R4", 1, 0, 0, 1, 1, 1, 1, 3, 2);
        // R5: foreign source
        step("R5", 1, 0, 0, 1, 1, 5, 5, 11, 11);
        // R6: arrival from up port
        step("R6", 1, 0, 5, 1, 1, 1, 1, 11, 11);
        // R8: bypass only from local input
        step("R8", 1, 0, 2, 1, 1, 1, 1, 11, 11);
        // R9: corner variant, south and west inputs
        step("R9", 1, 0, 3, 0, 0, 0, 0, 11, 11);
        step("R9", 1, 0, 4, 0, 0, 0, 0, 11, 11);
        step("R9", 1, 0, 2, 0, 0, 0, 0, 11, 11);
        // R7: body flits with a changed header keep the head request
        step("R7", 1, 1, 0, 4, 4, 9, 9, 8, 4);
        step("R7", 1, 1, 0, 4, 4, 9, 9, 0, 4);
        step("R7", 0, 0, 0, 4, 4, 9, 9, 4, 4);
        step("R7", 1, 0, 0, 4, 4, 9, 9, 4, 4);
        step("R7", 1, 0, 0, 4, 4, 9, 9, 4, 4);
        // R10: reset mid-packet discards held request
        step("R10", 1, 1, 0, 4, 4, 9, 9, 8, 4);
        set_reset(1'b0);
        set_reset(1'b1);
        step("R10", 1, 0, 0, 4, 4, 9, 9, 0, 4);
        // random packets with constant headers
        for (int p = 0; p < 1500; p++) begin
            int cx, cy, sx, sy, dx, dy, ip, len;
            cx = $urandom_range(0, MX - 1); cy = $urandom_range(0, MY - 1);
            if ($urandom_range(0, 1) == 1) begin
                sx = (cx / E) * E + $urandom_range(0, E - 1);
                sy = (cy / E) * E + $urandom_range(0, E - 1);
            end else begin
                sx = $urandom_range(0, MX - 1); sy = $urandom_range(0, MY - 1);
            end
            dx = $urandom_range(0, MX - 1); dy = $urandom_range(0, MY - 1);
            ip = $urandom_range(0, 5);
            len = $urandom_range(1, 3);
            for (int f = 0; f < len; f++) begin
                step("R1/R3/R5", 1, (f < len - 1), ip, cx, cy, sx, sy, dx, dy);
            end
            if ($urandom_range(0, 3) == 0) step("R1", 0, 0, 0, cx, cy, sx, sy, dx, dy);
        end
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule